// File: doc/BRIEF.md
# Fractional-Zoom Horizontal Box Filter

This block is a pipeline stage on the raster output path. It reduces aliasing when a horizontal zoom below 1x places several source pixels into one output pixel. Each clock it can take one source pixel with three 8-bit colour channels. It never stalls. The pixel is weighted into a per-channel collector. When the collector holds one full output pixel's worth of input, the block emits the weighted average.

The zoom step sets how much of an output pixel one input pixel covers, in 1/128 units. A step of 128 passes pixels straight through. A step of 64 averages pairs. A step of 48 makes each output span two and two-thirds inputs. An input pixel that crosses a bucket boundary is split. The part that fits goes into the closing bucket, and the rest starts the next one. A start-of-line pulse throws away any partial bucket, so buckets line up with the left edge of every line.

Top module: `zoom_box_filter`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and pix_o is 0.
- R2: The effective step is step_i for values 1 to 128. A step_i of 0 acts as 1, and any step_i above 128 acts as 128. One bucket holds 128 units.
- R3: The bucket fill level stays below 128 units between pixels.
- R4: Take an accepted pixel with effective step s while the bucket already holds f units. If f+s is below 128, the pixel adds weight s. If f+s is 128 or more, the pixel adds weight 128-f to the closing bucket. It then opens the next bucket with weight f+s-128.
- R5: Each channel of an emitted pixel equals the weighted sum of that channel over the bucket, shifted right by 7, saturated at 255.
- R6: valid_o is high exactly 2 clock cycles after the accepted pixel that completes a bucket, and at no other time.
- R7: When sol_i is high, the fill level and all accumulators clear before the pixel presented in the same cycle (if valid_i) is taken as the first pixel of the line. The partial bucket is discarded.
- R8: A cycle with valid_i low changes neither the fill level nor the accumulators, and it produces no output.
- R9: pix_i and pix_o pack red in bits 23:16, green in 15:8 and blue in 7:0, and the channels are filtered independently.
- R10: At an effective step of 128, every accepted pixel completes a bucket. The output then repeats the input with a latency of 2 cycles, at one pixel per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Source pixel present this cycle |
| sol_i | input | 1 | Start of line; clears the partial bucket |
| pix_i | input | 24 | Source pixel {R,G,B} |
| step_i | input | 8 | Zoom step in 1/128 output-pixel units |
| pix_o | output | 24 | Averaged pixel {R,G,B} |
| valid_o | output | 1 | Averaged pixel valid |

## Verification
The assertions assume that step_i only changes in ways the normalisation of R2 covers. They assume the source keeps valid_i meaningful on every cycle after reset. They also assume a completed bucket's weighted sum never exceeds 255 times 128, which follows from the bucket weight always totalling exactly 128 units. The stimulus draws steps across the full 0 to 255 range. That range takes in the clamped values 0 and anything above 128. The stimulus also mixes idle gaps and mid-bucket start-of-line pulses into random pixel streams. Directed runs cover pass-through, pair averaging, a straddling step of 48 and all-ones saturation.

// File: rtl/zbf_pkg.sv
package zbf_pkg;
  localparam int unsigned NUM_CH = 3;
  localparam int unsigned CH_W   = 8;
endpackage

// File: rtl/zbf_fill_tracker.sv
module zbf_fill_tracker #(
  parameter int unsigned STEP_W = 8,
  parameter int unsigned FRAC_W = 7,
  localparam int unsigned FILL_W = FRAC_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sol_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [FILL_W-1:0] w_cur_o,
  output logic [FILL_W-1:0] w_next_o,
  output logic              close_o,
  output logic              done_o
);
  localparam logic [FILL_W-1:0] FULL = FILL_W'(1) << FRAC_W;

  logic [FILL_W-1:0] fill_q, fill_base, room, step_eff;

  always_comb begin
    if (step_i == '0)                  step_eff = FILL_W'(1);
    else if (step_i > STEP_W'(FULL))   step_eff = FULL;
    else                               step_eff = FILL_W'(step_i);
  end

  assign fill_base = sol_i ? '0 : fill_q;
  assign room      = FULL - fill_base;
  assign close_o   = valid_i && (step_eff >= room);
  assign w_cur_o   = close_o ? room : step_eff;
  assign w_next_o  = close_o ? (step_eff - room) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= close_o;
      if (valid_i)    fill_q <= close_o ? w_next_o : fill_base + step_eff;
      else if (sol_i) fill_q <= '0;
    end
  end

  a_r3_fill_below_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q < FULL);

  a_r8_idle_keeps_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !sol_i) |=> (fill_q == $past(fill_q)));
endmodule

// File: rtl/zbf_chan_acc.sv
module zbf_chan_acc #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned FILL_W = 8,
  parameter int unsigned ACC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sol_i,
  input  logic              close_i,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic [FILL_W-1:0] w_cur_i,
  input  logic [FILL_W-1:0] w_next_i,
  output logic [ACC_W-1:0]  sum_o
);
  logic [ACC_W-1:0] acc_q, acc_base, prod_cur, prod_next, total;

  assign prod_cur  = ACC_W'(pix_i) * ACC_W'(w_cur_i);
  assign prod_next = ACC_W'(pix_i) * ACC_W'(w_next_i);
  assign acc_base  = sol_i ? '0 : acc_q;
  assign total     = acc_base + prod_cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      sum_o <= '0;
    end else if (valid_i) begin
      if (close_i) begin
        acc_q <= prod_next;
        sum_o <= total;
      end else begin
        acc_q <= total;
      end
    end else if (sol_i) begin
      acc_q <= '0;
    end
  end
endmodule

// File: rtl/zbf_out_stage.sv
module zbf_out_stage #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned ACC_W  = 16,
  parameter int unsigned FRAC_W = 7,
  parameter int unsigned NCH    = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 done_i,
  input  logic [NCH*ACC_W-1:0] sums_i,
  output logic [NCH*PIX_W-1:0] pix_o,
  output logic                 valid_o
);
  localparam logic [ACC_W-1:0] PMAX = ACC_W'((1 << PIX_W) - 1);

  logic [NCH*PIX_W-1:0] avg;

  for (genvar c = 0; c < NCH; c++) begin : g_sat
    logic [ACC_W-1:0] shifted;
    assign shifted = sums_i[c*ACC_W +: ACC_W] >> FRAC_W;
    assign avg[c*PIX_W +: PIX_W] = (shifted > PMAX) ? PMAX[PIX_W-1:0] : shifted[PIX_W-1:0];

    a_r5_sum_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |-> (sums_i[c*ACC_W +: ACC_W] <= (PMAX << FRAC_W)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= done_i;
      if (done_i) pix_o <= avg;
    end
  end
endmodule

// File: rtl/zoom_box_filter.sv
module zoom_box_filter
  import zbf_pkg::*;
#(
  parameter int unsigned PIX_W  = CH_W,
  parameter int unsigned STEP_W = 8,
  parameter int unsigned FRAC_W = 7,
  parameter int unsigned ACC_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    sol_i,
  input  logic [NUM_CH*PIX_W-1:0] pix_i,
  input  logic [STEP_W-1:0]       step_i,
  output logic [NUM_CH*PIX_W-1:0] pix_o,
  output logic                    valid_o
);
  localparam int unsigned FILL_W = FRAC_W + 1;

  logic [FILL_W-1:0]       w_cur, w_next;
  logic                    close, done;
  logic [NUM_CH*ACC_W-1:0] sums;

  zbf_fill_tracker #(.STEP_W(STEP_W), .FRAC_W(FRAC_W)) u_fill (
    .clk_i, .rst_ni, .valid_i, .sol_i, .step_i,
    .w_cur_o(w_cur), .w_next_o(w_next), .close_o(close), .done_o(done)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    zbf_chan_acc #(.PIX_W(PIX_W), .FILL_W(FILL_W), .ACC_W(ACC_W)) u_acc (
      .clk_i, .rst_ni, .valid_i, .sol_i,
      .close_i (close),
      .pix_i   (pix_i[c*PIX_W +: PIX_W]),
      .w_cur_i (w_cur),
      .w_next_i(w_next),
      .sum_o   (sums[c*ACC_W +: ACC_W])
    );
  end

  zbf_out_stage #(.PIX_W(PIX_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W), .NCH(NUM_CH)) u_out (
    .clk_i, .rst_ni,
    .done_i (done),
    .sums_i (sums),
    .pix_o,
    .valid_o
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_quiet: assert (!valid_o && pix_o == '0);
  end

  a_r6_latency_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close |-> ##2 valid_o);

  a_r6_latency_bwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !close |-> ##2 !valid_o);

  a_r8_idle_no_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 !valid_o);
endmodule

// File: tb/zoom_box_filter_bench.sv
module zoom_box_filter_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, sol_i = 1'b0;
  logic [23:0] pix_i = '0;
  logic [7:0]  step_i = 8'd128;
  logic [23:0] pix_o;
  logic        valid_o;

  int unsigned n_chk = 0, n_bad = 0;
  int unsigned cyc = 0;
  bit          finished = 0;
  string       tag = "R1";

  int unsigned m_fill = 0;
  int unsigned m_acc [3];
  bit          ex_v [4];
  logic [23:0] ex_p [4];

  always #4 clk = ~clk;

  zoom_box_filter u_zoom_box_filter (
    .clk_i(clk), .rst_ni, .valid_i, .sol_i, .pix_i, .step_i, .pix_o, .valid_o
  );

  function automatic int unsigned eff_step(input logic [7:0] s);
    if (s == 0) return 1;
    if (s > 128) return 128;
    return s;
  endfunction

  function automatic logic [7:0] avg_of(input int unsigned sum);
    int unsigned q = sum >> 7;
    return (q > 255) ? 8'd255 : q[7:0];
  endfunction

  task automatic check(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", t, act, exp, cyc);
    end
  endtask

  task automatic step_cyc(input bit v, input bit sol, input logic [7:0] st, input logic [23:0] p);
    int unsigned slot, nslot, s, a;
    logic [23:0] outp;
    @(negedge clk);
    slot = cyc % 4;
    check(valid_o == ex_v[slot], {tag, " valid_o (R6)"}, 32'(valid_o), 32'(ex_v[slot]));
    if (ex_v[slot])
      check(pix_o == ex_p[slot], {tag, " pix_o (R5)"}, 32'(pix_o), 32'(ex_p[slot]));
    ex_v[slot] = 0;
    valid_i = v; sol_i = sol; step_i = st; pix_i = p;
    nslot = (cyc + 2) % 4;
    if (sol) begin
      m_fill = 0;
      for (int c = 0; c < 3; c++) m_acc[c] = 0;
    end
    if (v) begin
      s = eff_step(st);
      if (m_fill + s < 128) begin
        for (int c = 0; c < 3; c++) m_acc[c] += p[c*8 +: 8] * s;
        m_fill += s;
      end else begin
        a = 128 - m_fill;
        for (int c = 0; c < 3; c++) begin
          outp[c*8 +: 8] = avg_of(m_acc[c] + p[c*8 +: 8] * a);
          m_acc[c] = p[c*8 +: 8] * (s - a);
        end
        m_fill = s - a;
        ex_v[nslot] = 1;
        ex_p[nslot] = outp;
      end
    end
    cyc++;
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) step_cyc(0, 0, step_i, '0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin ex_v[i] = 0; ex_p[i] = '0; end
    for (int c = 0; c < 3; c++) m_acc[c] = 0;
    void'($urandom(32'h5eed_1234));
    // R1: quiet during reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(valid_o == 0 && pix_o == 0, "R1 reset outputs", {7'd0, valid_o, pix_o}, 32'd0);
    end
    @(negedge clk); rst_ni = 1'b1;

    // R10 / R9: pass-through at step 128, distinct channels
    tag = "R10";
    step_cyc(1, 1, 128, 24'h12_34_56);
    step_cyc(1, 0, 128, 24'hff_00_80);
    step_cyc(1, 0, 128, 24'h01_fe_7f);
    tag = "R9";
    step_cyc(1, 0, 128, 24'hab_00_00);
    step_cyc(1, 0, 128, 24'h00_cd_00);
    flush();

    // pair averaging at step 64
    tag = "R5";
    step_cyc(1, 1, 64, 24'h10_20_30);
    step_cyc(1, 0, 64, 24'h30_40_51);
    step_cyc(1, 0, 64, 24'hff_ff_ff);
    step_cyc(1, 0, 64, 24'hff_ff_ff);
    flush();

    // R4: straddling step 48 (f=96 then s=48 splits 32/16)
    tag = "R4";
    step_cyc(1, 1, 48, 24'h80_40_20);
    for (int i = 0; i < 10; i++) step_cyc(1, 0, 48, 24'(i * 24'h111111 + 24'h0a0b0c));
    flush();

    // R2: step 0 acts as 1, 200 acts as 128
    tag = "R2";
    step_cyc(1, 1, 200, 24'h55_66_77);
    step_cyc(1, 0, 255, 24'h88_99_aa);
    step_cyc(1, 1, 0, 24'h04_04_04);
    for (int i = 0; i < 130; i++) step_cyc(1, 0, 0, 24'h04_04_04 + 24'(i));
    flush();

    // R7: start of line discards partial bucket
    tag = "R7";
    step_cyc(1, 1, 32, 24'hff_ff_ff);
    step_cyc(1, 0, 32, 24'hff_ff_ff);
    step_cyc(1, 1, 32, 24'h00_00_00);
    step_cyc(1, 0, 32, 24'h00_00_00);
    step_cyc(1, 0, 32, 24'h00_00_00);
    step_cyc(1, 0, 32, 24'h00_00_00);
    step_cyc(0, 1, 32, 24'hff_ff_ff);
    step_cyc(1, 0, 128, 24'h21_22_23);
    flush();

    // R8: gaps leave bucket untouched
    tag = "R8";
    step_cyc(1, 1, 64, 24'h40_40_40);
    for (int i = 0; i < 5; i++) step_cyc(0, 0, 64, 24'hff_ff_ff);
    step_cyc(1, 0, 64, 24'h20_20_20);
    flush();

    // R3/R5: all-ones saturation edge with odd step
    tag = "R3";
    step_cyc(1, 1, 37, 24'hff_ff_ff);
    for (int i = 0; i < 20; i++) step_cyc(1, 0, 37, 24'hff_ff_ff);
    flush();

    // random mix
    tag = "RND R4";
    for (int blk = 0; blk < 40; blk++) begin
      logic [7:0] st = 8'($urandom);
      for (int i = 0; i < 200; i++) begin
        bit v = ($urandom % 10) < 8;
        bit sl = ($urandom % 60) == 0;
        step_cyc(v, sl, st, 24'($urandom));
      end
    end
    flush();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule